// File: doc/BRIEF.md
# Pulse-Interval Frame Decoder

This block sits on the card side of a proximity link. It recovers the frames that a reader sends as carrier pauses. The input is the digitised carrier envelope. The block counts ticks between successive rising edges of that envelope. An enable input, generated elsewhere, supplies the ticks. The block sorts each measured interval into a long symbol (logic one) or a short symbol (logic zero), with a fixed tolerance around each nominal length. An interval that fits neither window is discarded.

Decoded bits are packed into a frame word starting at bit 0. A frame ends once the envelope stays quiet for longer than the longest legal symbol. The block then publishes the word and its length, together with a one-cycle valid strobe. Short bursts of four bits or fewer are treated as noise and dropped without any report. Decryption and command parsing happen downstream.

Top module: `pulse_frame_decoder`

## Requirements
- R1: Reset sets frameValid to 0, frameData to 0 and frameBits to 0.
- R2: An interval is the number of cycles with tickEn high, counted from the cycle in which a rising edge of envIn is seen up to the cycle before the next rising edge. Cycles with tickEn low add nothing to it.
- R3: An interval of 101 to 139 ticks, both inclusive, appends a 1. Intervals of exactly 100 or 140 ticks do not append a 1.
- R4: An interval of 41 to 79 ticks, both inclusive, appends a 0. Intervals of exactly 40 or 80 ticks do not append a 0.
- R5: Decoded bits fill frameData starting at bit 0. The first bit goes to bit 0, the next to bit 1, and so on. frameBits reports how many bits were stored.
- R6: An interval that matches neither window appends nothing. It does not end the current frame, and bits decoded after it continue at the next free position.
- R7: Once at least one bit has been decoded, the frame ends when 140 ticks pass after the last rising edge with no new rising edge. For a frame of more than 4 bits, frameValid is high for exactly one cycle. That cycle begins at the clock edge after the one where the 140th tick is counted.
- R8: A frame that ends with 4 or fewer stored bits raises no frameValid and leaves frameData and frameBits unchanged. A frame with exactly 5 bits is reported.
- R9: A frame stores at most 31 bits. Later bits in the same frame are dropped and frameBits stays at 31.
- R10: frameData and frameBits change only in the cycle in which frameValid is high. Between reports they keep their values.
- R11: The interval counter stops once 2400 ticks pass with no rising edge. The next rising edge only starts a new measurement and decodes no bit. The counter does not wrap around in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Qualifies a cycle as one timing tick |
| envIn | input | 1 | Digitised carrier envelope |
| frameData | output | 31 | Bits of the last reported frame, first bit in bit 0 |
| frameBits | output | 5 | Number of bits in the last reported frame |
| frameValid | output | 1 | One-cycle strobe marking a new report |

## Verification
Bits are decoded on the rising edge that closes an interval, and only the final report is visible at the ports. With ticks on every cycle, the strobe is therefore due 140 cycles after the clock edge that registers the last rising edge. When ticks arrive every d-th cycle, aligned to that edge, it is due 139·d+1 cycles after it. For every cycle of the quiet period, the bench compares frameValid with the expected value. It compares the data and the count in exactly the predicted cycle. It also checks that no strobe appears while the frame is still being received.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic restart;    // rising edge seen: start a new interval
    logic appendBit;  // store bitVal at the next free position
    logic bitVal;
    logic endFrame;   // quiet gap elapsed: close and clear the frame
    logic publish;    // closed frame is long enough to report
  } pfdCtrl_t;
endpackage

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int MAX_BITS    = 31,
  parameter int MIN_REPORT  = 5,
  parameter int STOP_TICKS  = 2400,
  localparam int TIMER_W    = $clog2(STOP_TICKS + 1),
  localparam int COUNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  pfdCtrl_t            ctrl,
  output logic [TIMER_W-1:0]  timerVal,
  output logic                timerRunning,
  output logic [COUNT_W-1:0]  bitCount,
  output logic [MAX_BITS-1:0] frameData,
  output logic [COUNT_W-1:0]  frameBits,
  output logic                frameValid
);
  logic [MAX_BITS-1:0] accWord;

  // Interval counter: reloads on an edge, freezes at the idle limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerVal     <= '0;
      timerRunning <= 1'b0;
    end else if (ctrl.restart) begin
      timerVal     <= tickEn ? TIMER_W'(1) : '0;
      timerRunning <= 1'b1;
    end else if (timerRunning) begin
      if (timerVal >= TIMER_W'(STOP_TICKS)) timerRunning <= 1'b0;
      else if (tickEn) timerVal <= timerVal + 1'b1;
    end
  end

  // One write enable per bit position of the frame word
  for (genvar i = 0; i < MAX_BITS; i++) begin : g_acc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accWord[i] <= 1'b0;
      else if (ctrl.endFrame) accWord[i] <= 1'b0;
      else if (ctrl.appendBit && bitCount == COUNT_W'(i)) accWord[i] <= ctrl.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCount <= '0;
    else if (ctrl.endFrame) bitCount <= '0;
    else if (ctrl.appendBit && bitCount < COUNT_W'(MAX_BITS)) bitCount <= bitCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameData  <= '0;
      frameBits  <= '0;
      frameValid <= 1'b0;
    end else begin
      frameValid <= ctrl.publish;
      if (ctrl.publish) begin
        frameData <= accWord;
        frameBits <= bitCount;
      end
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timerVal <= TIMER_W'(STOP_TICKS)); // R11
  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!timerRunning && !ctrl.restart) |=> $stable(timerVal)); // R11
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= COUNT_W'(MAX_BITS)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid); // R7
  AST_REPORT_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> frameBits >= COUNT_W'(MIN_REPORT)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(frameBits) || !$stable(frameData)) |-> frameValid); // R10
endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
#(
  parameter int ONE_TICKS   = 120,
  parameter int ZERO_TICKS  = 60,
  parameter int FUZZ_TICKS  = 20,
  parameter int MAX_BITS    = 31,
  parameter int MIN_REPORT  = 5,
  parameter int STOP_TICKS  = 2400,
  localparam int GAP_TICKS  = ONE_TICKS + FUZZ_TICKS,
  localparam int TIMER_W    = $clog2(STOP_TICKS + 1),
  localparam int COUNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               envIn,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic               timerRunning,
  input  logic [COUNT_W-1:0] bitCount,
  output pfdCtrl_t           ctrl
);
  logic envPrev;
  logic frameActive;
  logic riseEdge, isOne, isZero;

  assign riseEdge = envIn && !envPrev;
  assign isOne  = (timerVal > TIMER_W'(ONE_TICKS - FUZZ_TICKS)) &&
                  (timerVal < TIMER_W'(ONE_TICKS + FUZZ_TICKS));
  assign isZero = (timerVal > TIMER_W'(ZERO_TICKS - FUZZ_TICKS)) &&
                  (timerVal < TIMER_W'(ZERO_TICKS + FUZZ_TICKS));

  always_comb begin
    ctrl.restart   = riseEdge;
    ctrl.appendBit = riseEdge && timerRunning && (isOne || isZero);
    ctrl.bitVal    = isOne;
    ctrl.endFrame  = frameActive && (timerVal >= TIMER_W'(GAP_TICKS));
    ctrl.publish   = ctrl.endFrame && (bitCount >= COUNT_W'(MIN_REPORT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      envPrev     <= 1'b0;
      frameActive <= 1'b0;
    end else begin
      envPrev <= envIn;
      if (ctrl.endFrame) frameActive <= 1'b0;
      else if (ctrl.appendBit) frameActive <= 1'b1;
    end
  end

  AST_END_NOT_APPEND: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.appendBit && ctrl.endFrame)); // R7
  AST_APPEND_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.appendBit |=> frameActive); // R5
  AST_IDLE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    !timerRunning |-> !frameActive); // R11
endmodule

// File: rtl/pulse_frame_decoder.sv
module pulse_frame_decoder
  import pfd_pkg::*;
#(
  parameter int ONE_TICKS   = 120,
  parameter int ZERO_TICKS  = 60,
  parameter int FUZZ_TICKS  = 20,
  parameter int MAX_BITS    = 31,
  parameter int MIN_REPORT  = 5,
  parameter int STOP_TICKS  = 2400,
  localparam int TIMER_W    = $clog2(STOP_TICKS + 1),
  localparam int COUNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                envIn,
  output logic [MAX_BITS-1:0] frameData,
  output logic [COUNT_W-1:0]  frameBits,
  output logic                frameValid
);
  pfdCtrl_t           ctrl;
  logic [TIMER_W-1:0] timerVal;
  logic               timerRunning;
  logic [COUNT_W-1:0] bitCount;

  pfd_control #(
    .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS), .FUZZ_TICKS(FUZZ_TICKS),
    .MAX_BITS(MAX_BITS), .MIN_REPORT(MIN_REPORT), .STOP_TICKS(STOP_TICKS)
  ) i_control (
    .clk(clk), .rstN(rstN), .envIn(envIn), .timerVal(timerVal),
    .timerRunning(timerRunning), .bitCount(bitCount), .ctrl(ctrl)
  );

  pfd_datapath #(
    .MAX_BITS(MAX_BITS), .MIN_REPORT(MIN_REPORT), .STOP_TICKS(STOP_TICKS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrl(ctrl),
    .timerVal(timerVal), .timerRunning(timerRunning), .bitCount(bitCount),
    .frameData(frameData), .frameBits(frameBits), .frameValid(frameValid)
  );
endmodule

// File: tb/test_pulse_frame_decoder.sv
module test_pulse_frame_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        envIn = 1'b0;
  logic [30:0] frameData;
  logic [4:0]  frameBits;
  logic        frameValid;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;
  int ivals[$];
  logic [30:0] lastData = '0;
  int lastBits = 0;

  always #5 clk = ~clk;

  pulse_frame_decoder i_pulse_frame_decoder (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .envIn(envIn),
    .frameData(frameData), .frameBits(frameBits), .frameValid(frameValid)
  );

  task automatic checkEq(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 1 = long symbol, 0 = short symbol, -1 = no match
  function automatic int classify(input int t);
    if (t > 100 && t < 140) return 1;
    if (t > 40 && t < 80) return 0;
    return -1;
  endfunction

  // Rising edge in the first cycle, then low; ticks on every div-th cycle
  task automatic pulse(input int ticks, input int div, inout int spurious);
    for (int c = 0; c < ticks * div; c++) begin
      envIn  = (c == 0);
      tickEn = (c % div == 0);
      @(negedge clk);
      if (frameValid) spurious++;
    end
  endtask

  task automatic runFrame(input int div, input string req);
    logic [30:0] expData = '0;
    int expBits = 0;
    int spurious = 0;
    bit report;
    int due = 139 * div + 1;
    for (int k = 0; k < ivals.size(); k++) begin
      int b = classify(ivals[k]);
      if (b >= 0 && expBits < 31) begin
        expData[expBits] = b[0];
        expBits++;
      end
    end
    report = (expBits > 4);
    for (int k = 0; k < ivals.size(); k++) pulse(ivals[k], div, spurious);
    checkEq("R7", {req, " no report while receiving"}, spurious, 0);
    checkEq("R10", {req, " data held before report"}, frameData, lastData);
    checkEq("R10", {req, " count held before report"}, frameBits, lastBits);
    // closing edge, then quiet gap
    for (int c = 0; c <= due + 2; c++) begin
      envIn  = (c == 0);
      tickEn = (c % div == 0);
      @(negedge clk);
      if (c >= 1) checkEq("R7", {req, " valid timing"}, frameValid, (report && c == due));
      if (c == due) begin
        if (report) begin
          lastData = expData;
          lastBits = expBits;
        end
        checkEq("R5", {req, " frame data"}, frameData, lastData);
        checkEq("R9", {req, " frame bit count"}, frameBits, lastBits);
      end
    end
    envIn = 1'b0;
    tickEn = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    checkEq("R1", "valid in reset", frameValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "valid after reset", frameValid, 0);
    checkEq("R1", "data after reset", frameData, 0);
    checkEq("R1", "count after reset", frameBits, 0);

    // R3 R4 window edges inside: 1,1,0,0,1,0 -> 0x13, 6 bits
    ivals = '{101, 139, 41, 79, 120, 60};
    runFrame(1, "R3/R4 inner bounds");
    checkEq("R5", "lsb first word", frameData, 31'h13);

    // R6 unmatched intervals 100, 40, 80 skipped -> 1,0,1,0,1 = 0x15
    ivals = '{120, 100, 60, 40, 80, 120, 60, 120};
    runFrame(1, "R6 skip unmatched");
    checkEq("R6", "skipped word", frameData, 31'h15);

    // R8 four bits: dropped, outputs keep 0x15/5
    ivals = '{120, 120, 120, 120};
    runFrame(1, "R8 short drop");
    checkEq("R8", "data after drop", frameData, 31'h15);

    // R8 exactly five bits reported: 0,0,0,0,1 -> 0x10
    ivals = '{60, 60, 60, 60, 120};
    runFrame(1, "R8 five bits");
    checkEq("R8", "five-bit count", frameBits, 5);

    // R9 cap: 35 alternating bits, only 31 kept
    ivals.delete();
    for (int k = 0; k < 35; k++) ivals.push_back((k % 2 == 0) ? 120 : 60);
    runFrame(1, "R9 cap");
    checkEq("R9", "capped count", frameBits, 31);

    // R2 tick gating, one tick every second cycle: 1,0,0,1,1 -> 0x19
    ivals = '{120, 60, 60, 120, 120};
    runFrame(2, "R2 gated ticks");
    checkEq("R2", "gated word", frameData, 31'h19);

    // R11 long idle leading interval (would alias to 120 on wrap) -> 0,1,1,0,0
    ivals = '{4216, 60, 120, 120, 60, 60};
    runFrame(1, "R11 idle stop");
    checkEq("R11", "word after idle", frameData, 31'h06);

    // Random frames mixing matched and unmatched intervals
    for (int f = 0; f < 10; f++) begin
      int n = 5 + $urandom_range(28, 0);
      ivals.delete();
      for (int k = 0; k < n; k++) begin
        int r = $urandom_range(9, 0);
        if (r == 0)      ivals.push_back($urandom_range(40, 20));
        else if (r == 1) ivals.push_back($urandom_range(100, 80));
        else if (r < 6)  ivals.push_back($urandom_range(139, 101));
        else             ivals.push_back($urandom_range(79, 41));
      end
      runFrame(1, "R3/R4/R6 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL R7 watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule